// File: doc/BRIEF.md
# USB Control Endpoint Stage Sequencer

This block chooses the handshake or packet type a USB device's control endpoint returns to each host token during a control transfer. The token decoder signals SETUP, IN and OUT events, the data direction carried by the SETUP request, the fill level of the endpoint buffer, and the moment the host acknowledges a packet the device sent. Firmware steers the transfer through an 8-bit control register. That register can force a stall, request the status handshake, open the data stage, and mark the buffer as ready to send or empty it.

The data stage does not open just because the buffer holds data. A separate enable bit must also be set, and it drops by itself once one data transaction completes. A byte-count register lets the buffer mark itself ready when its fill level reaches a programmed short-packet length. In that case firmware needs no ready write. Completed data transactions and SETUP receptions each raise a one-cycle interrupt. A completed status handshake does not.

Top module: `ctlep_stage_seq`

## Requirements
- R1: After reset the control register reads 0x00, `rsp_valid`, `ep_irq` and `buf_clear` are 0, and the byte-count register is 0.
- R2: The control register reads back as: bit 0 stall, bit 1 status-handshake request, bit 2 data-stage enable, bit 3 buffer-ready flag. Bit 4 (buffer clear) and bits 7..5 always read 0. Writing 0 to bit 3 leaves the ready flag unchanged.
- R3: A token's response appears on `rsp_code` with `rsp_valid` high for exactly one cycle, one clock after the token. Codes are: 1 ACK, 2 NAK, 3 STALL, 4 data packet, 5 zero-length packet.
- R4: While stall is set, every IN and OUT token is answered STALL, whatever the other bits hold.
- R5: In an OUT data stage, an OUT token is answered ACK when the enable bit is set and NAK otherwise. An ACK clears the enable bit at the same edge.
- R6: In an IN data stage, an IN token is answered with a data packet only when both the enable bit and the ready flag are set, and NAK otherwise. A host acknowledge of that packet clears both bits.
- R7: While the status request is set, IN is answered with a zero-length packet and OUT with ACK. The request clears when the host acknowledges the zero-length packet, or when the device ACKs the OUT.
- R8: A completed status handshake raises no interrupt.
- R9: In an IN data stage with a nonzero byte count, the ready flag sets by itself one clock after the fill level equals the byte count.
- R10: Writing 1 to bit 4 clears the ready flag and raises `buf_clear` for one cycle, both one clock after the write. This clear wins over a ready write in the same cycle.
- R11: A SETUP token is answered ACK, clears stall, status request, enable and ready flag, latches the data direction, and raises an interrupt.
- R12: `ep_irq` pulses one cycle after an ACKed data OUT token, and one cycle after the host acknowledge of a data packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write value |
| cfg_rd_data | output | 8 | Control register read value |
| blen_wr_en | input | 1 | Byte-count register write strobe |
| blen_wr_data | input | 16 | Byte-count write value |
| tok_setup | input | 1 | SETUP token received |
| setup_dir_in | input | 1 | Data direction of the SETUP request (1 = IN) |
| tok_in | input | 1 | IN token received |
| tok_out | input | 1 | OUT token received |
| host_ack | input | 1 | Host acknowledged the packet last sent |
| buf_fill | input | 16 | Bytes currently held in the endpoint buffer |
| rsp_valid | output | 1 | Response code valid |
| rsp_code | output | 3 | Response code |
| buf_clear | output | 1 | Request to empty the buffer |
| ep_irq | output | 1 | Control endpoint interrupt pulse |

## Verification
A stuck or stale enable bit shows at the next data token of the same direction: the response is ACK or a data packet instead of NAK, or the reverse. A status request that never clears turns the next IN into a zero-length packet instead of data. Self-clearing bits and the ready flag can be read back through the control register one clock after the event, and a wrong interrupt decision is visible on `ep_irq` in that same cycle.

// File: rtl/ctlep_pkg.sv
package ctlep_pkg;

    localparam int CFG_W     = 8;
    localparam int B_STALL   = 0;
    localparam int B_STATUS  = 1;
    localparam int B_DSEN    = 2;
    localparam int B_READY   = 3;
    localparam int B_CLEAR   = 4;

    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_ACK   = 3'd1,
        RSP_NAK   = 3'd2,
        RSP_STALL = 3'd3,
        RSP_DATA  = 3'd4,
        RSP_ZLP   = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        PND_NONE = 2'd0,
        PND_DIN  = 2'd1,
        PND_ZLP  = 2'd2
    } pend_e;

    typedef struct packed {
        logic stall;
        logic status;
        logic dsen;
        logic dir_in;
    } ctl_state_t;

    typedef struct packed {
        logic setup;
        logic tin;
        logic tout;
        logic hack;
    } tok_t;

    typedef struct packed {
        logic out_data_ack;
        logic in_data_done;
        logic st_out_ack;
        logic st_in_done;
    } hs_ev_t;

    function automatic rsp_e pick_in(ctl_state_t s, logic ready);
        if (s.stall)                           return RSP_STALL;
        else if (s.status)                     return RSP_ZLP;
        else if (s.dir_in && s.dsen && ready)  return RSP_DATA;
        else                                   return RSP_NAK;
    endfunction

    function automatic rsp_e pick_out(ctl_state_t s);
        if (s.stall)                  return RSP_STALL;
        else if (s.status)            return RSP_ACK;
        else if (!s.dir_in && s.dsen) return RSP_ACK;
        else                          return RSP_NAK;
    endfunction

endpackage

// File: rtl/ctlep_ctl_regs.sv
module ctlep_ctl_regs
    import ctlep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             setup,
    input  logic             setup_dir_in,
    input  hs_ev_t           ev,
    output ctl_state_t       st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (setup) begin
            st.stall  <= 1'b0;
            st.status <= 1'b0;
            st.dsen   <= 1'b0;
            st.dir_in <= setup_dir_in;
        end else begin
            if (ev.out_data_ack || ev.in_data_done)
                st.dsen <= 1'b0;
            if (ev.st_out_ack || ev.st_in_done)
                st.status <= 1'b0;
            if (wr_en) begin
                st.stall  <= wr_data[B_STALL];
                st.status <= wr_data[B_STATUS];
                st.dsen   <= wr_data[B_DSEN];
            end
        end
    end

endmodule

// File: rtl/ctlep_buf_ready.sv
module ctlep_buf_ready
    import ctlep_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             blen_wr_en,
    input  logic [CNT_W-1:0] blen_wr_data,
    input  logic [CNT_W-1:0] fill,
    input  logic             dir_in,
    input  logic             setup,
    input  logic             in_done,
    output logic             ready,
    output logic             buf_clear
);

    logic [CNT_W-1:0] blen_q;
    logic             clr_req;
    logic             set_req;
    logic             auto_hit;

    assign clr_req  = wr_en && wr_data[B_CLEAR];
    assign auto_hit = dir_in && (blen_q != '0) && (fill == blen_q);
    assign set_req  = (wr_en && wr_data[B_READY]) || auto_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            blen_q    <= '0;
            ready     <= 1'b0;
            buf_clear <= 1'b0;
        end else begin
            if (blen_wr_en)
                blen_q <= blen_wr_data;
            buf_clear <= clr_req;
            if (clr_req || setup || in_done)
                ready <= 1'b0;
            else if (set_req)
                ready <= 1'b1;
        end
    end

endmodule

// File: rtl/ctlep_resp_unit.sv
module ctlep_resp_unit
    import ctlep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tok_t       tok,
    input  ctl_state_t st,
    input  logic       ready,
    output hs_ev_t     ev,
    output logic       rsp_valid,
    output rsp_e       rsp_code,
    output logic       irq,
    output pend_e      pend
);

    rsp_e in_code;
    rsp_e out_code;
    logic out_only;

    assign in_code  = pick_in(st, ready);
    assign out_code = pick_out(st);
    assign out_only = tok.tout && !tok.tin && !tok.setup;

    always_comb begin
        ev.out_data_ack = out_only && !st.stall && !st.status && out_code == RSP_ACK;
        ev.st_out_ack   = out_only && !st.stall && st.status;
        ev.in_data_done = tok.hack && !tok.setup && pend == PND_DIN;
        ev.st_in_done   = tok.hack && !tok.setup && pend == PND_ZLP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_NONE;
            irq       <= 1'b0;
            pend      <= PND_NONE;
        end else begin
            rsp_valid <= tok.setup || tok.tin || tok.tout;
            if (tok.setup)     rsp_code <= RSP_ACK;
            else if (tok.tin)  rsp_code <= in_code;
            else if (tok.tout) rsp_code <= out_code;
            else               rsp_code <= RSP_NONE;
            irq <= tok.setup || ev.out_data_ack || ev.in_data_done;
            if (tok.setup)
                pend <= PND_NONE;
            else if (tok.tin)
                pend <= (in_code == RSP_DATA) ? PND_DIN :
                        (in_code == RSP_ZLP)  ? PND_ZLP : PND_NONE;
            else if (tok.hack)
                pend <= PND_NONE;
        end
    end

endmodule

// File: rtl/ctlep_stage_seq.sv
module ctlep_stage_seq
    import ctlep_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_wr_data,
    output logic [7:0]       cfg_rd_data,
    input  logic             blen_wr_en,
    input  logic [CNT_W-1:0] blen_wr_data,
    input  logic             tok_setup,
    input  logic             setup_dir_in,
    input  logic             tok_in,
    input  logic             tok_out,
    input  logic             host_ack,
    input  logic [CNT_W-1:0] buf_fill,
    output logic             rsp_valid,
    output logic [2:0]       rsp_code,
    output logic             buf_clear,
    output logic             ep_irq
);

    ctl_state_t st;
    hs_ev_t     ev;
    tok_t       tok;
    rsp_e       code_q;
    pend_e      pend;
    logic       ready;

    assign tok = '{setup: tok_setup, tin: tok_in, tout: tok_out, hack: host_ack};

    ctlep_ctl_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cfg_wr_en),
        .wr_data      (cfg_wr_data),
        .setup        (tok_setup),
        .setup_dir_in (setup_dir_in),
        .ev           (ev),
        .st           (st)
    );

    ctlep_buf_ready #(.CNT_W(CNT_W)) u_ready (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cfg_wr_en),
        .wr_data      (cfg_wr_data),
        .blen_wr_en   (blen_wr_en),
        .blen_wr_data (blen_wr_data),
        .fill         (buf_fill),
        .dir_in       (st.dir_in),
        .setup        (tok_setup),
        .in_done      (ev.in_data_done),
        .ready        (ready),
        .buf_clear    (buf_clear)
    );

    ctlep_resp_unit u_resp (
        .clk       (clk),
        .rst       (rst),
        .tok       (tok),
        .st        (st),
        .ready     (ready),
        .ev        (ev),
        .rsp_valid (rsp_valid),
        .rsp_code  (code_q),
        .irq       (ep_irq),
        .pend      (pend)
    );

    assign rsp_code = code_q;

    always_comb begin
        cfg_rd_data           = '0;
        cfg_rd_data[B_STALL]  = st.stall;
        cfg_rd_data[B_STATUS] = st.status;
        cfg_rd_data[B_DSEN]   = st.dsen;
        cfg_rd_data[B_READY]  = ready;
    end

endmodule

// File: rtl/ctlep_stage_seq_chk.sv
module ctlep_stage_seq_chk
    import ctlep_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr_en,
    input logic       tok_setup,
    input logic       tok_in,
    input logic       tok_out,
    input logic       host_ack,
    input logic [7:0] cfg_rd_data,
    input logic       rsp_valid,
    input logic [2:0] rsp_code,
    input logic       ep_irq,
    input logic       stall,
    input logic       status,
    input logic       dsen,
    input logic       dir_in,
    input logic       ready,
    input logic [1:0] pend
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[7:4] == 4'b0);

    p_valid_follows_token_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(tok_setup || tok_in || tok_out));

    p_stall_first_r4: assert property (@(posedge clk) disable iff (rst)
        (tok_in && !tok_setup && stall) |=> rsp_code == RSP_STALL);

    p_out_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (tok_out && !tok_in && !tok_setup && !cfg_wr_en && dsen && !stall && !status && !dir_in)
        |=> (!dsen && rsp_code == RSP_ACK));

    p_data_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RSP_DATA) |-> $past(dsen && ready));

    p_status_zlp_r7: assert property (@(posedge clk) disable iff (rst)
        (tok_in && !tok_setup && status && !stall) |=> rsp_code == RSP_ZLP);

    p_status_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (host_ack && pend == PND_ZLP && !tok_setup && !tok_out) |=> !ep_irq);

    p_setup_clears_r11: assert property (@(posedge clk) disable iff (rst)
        tok_setup |=> (!stall && !status && !dsen && !ready && ep_irq));

endmodule

bind ctlep_stage_seq ctlep_stage_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .tok_setup   (tok_setup),
    .tok_in      (tok_in),
    .tok_out     (tok_out),
    .host_ack    (host_ack),
    .cfg_rd_data (cfg_rd_data),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .ep_irq      (ep_irq),
    .stall       (st.stall),
    .status      (st.status),
    .dsen        (st.dsen),
    .dir_in      (st.dir_in),
    .ready       (ready),
    .pend        (pend)
);

// File: tb/ctlep_stage_seq_bench.sv
module ctlep_stage_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic        blen_wr_en = 1'b0;
    logic [15:0] blen_wr_data = '0;
    logic        tok_setup = 1'b0;
    logic        setup_dir_in = 1'b0;
    logic        tok_in = 1'b0;
    logic        tok_out = 1'b0;
    logic        host_ack = 1'b0;
    logic [15:0] buf_fill = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_code;
    logic        buf_clear;
    logic        ep_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ctlep_stage_seq u_ctlep_stage_seq (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .cfg_rd_data  (cfg_rd_data),
        .blen_wr_en   (blen_wr_en),
        .blen_wr_data (blen_wr_data),
        .tok_setup    (tok_setup),
        .setup_dir_in (setup_dir_in),
        .tok_in       (tok_in),
        .tok_out      (tok_out),
        .host_ack     (host_ack),
        .buf_fill     (buf_fill),
        .rsp_valid    (rsp_valid),
        .rsp_code     (rsp_code),
        .buf_clear    (buf_clear),
        .ep_irq       (ep_irq)
    );

    localparam logic [2:0] ACK = 3'd1, NAK = 3'd2, STL = 3'd3, DAT = 4, ZLP = 5;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        step();
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
    endtask

    task automatic do_setup(logic dir);
        tok_setup = 1'b1; setup_dir_in = dir;
        step();
        tok_setup = 1'b0;
    endtask

    task automatic do_in();
        tok_in = 1'b1; step(); tok_in = 1'b0;
    endtask

    task automatic do_out();
        tok_out = 1'b1; step(); tok_out = 1'b0;
    endtask

    task automatic do_hack();
        host_ack = 1'b1; step(); host_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ctl reg", cfg_rd_data, 8'h00);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 irq", ep_irq, 0);
        check("R1 buf_clear", buf_clear, 0);
    endtask

    task automatic t_out_stage();
        do_setup(1'b0);
        check("R11 setup ack", {rsp_valid, rsp_code}, {1'b1, ACK});
        check("R11 setup irq", ep_irq, 1);
        do_out();
        check("R5 out nak without enable", rsp_code, NAK);
        check("R12 no irq on nak", ep_irq, 0);
        step();
        check("R3 valid one cycle", rsp_valid, 0);
        cfg_write(8'h04);
        check("R2 enable readback", cfg_rd_data, 8'h04);
        do_out();
        check("R5 out ack", {rsp_valid, rsp_code}, {1'b1, ACK});
        check("R12 irq on out ack", ep_irq, 1);
        check("R5 enable self clear", cfg_rd_data, 8'h00);
        do_out();
        check("R5 second out nak", rsp_code, NAK);
    endtask

    task automatic t_in_stage();
        do_setup(1'b1);
        cfg_write(8'h08);
        check("R2 ready readback", cfg_rd_data, 8'h08);
        do_in();
        check("R6 in nak without enable", rsp_code, NAK);
        cfg_write(8'h04);
        check("R2 ready kept on write 0", cfg_rd_data, 8'h0C);
        do_in();
        check("R6 data packet", rsp_code, DAT);
        check("R12 no irq before host ack", ep_irq, 0);
        do_hack();
        check("R12 irq on host ack", ep_irq, 1);
        check("R6 enable and ready clear", cfg_rd_data, 8'h00);
        do_in();
        check("R6 in nak after done", rsp_code, NAK);
    endtask

    task automatic t_status();
        cfg_write(8'h02);
        do_in();
        check("R7 in zlp", rsp_code, ZLP);
        do_hack();
        check("R7 status clears on host ack", cfg_rd_data, 8'h00);
        check("R8 no irq on zlp ack", ep_irq, 0);
        cfg_write(8'h02);
        do_out();
        check("R7 status out ack", rsp_code, ACK);
        check("R7 status clears on out", cfg_rd_data, 8'h00);
        check("R8 no irq on status out", ep_irq, 0);
    endtask

    task automatic t_stall();
        cfg_write(8'h0F);
        do_in();
        check("R4 in stall", rsp_code, STL);
        do_out();
        check("R4 out stall", rsp_code, STL);
        check("R4 stall held", cfg_rd_data[0], 1);
        do_setup(1'b1);
        check("R11 setup clears all", cfg_rd_data, 8'h00);
    endtask

    task automatic t_autoval();
        do_setup(1'b1);
        blen_wr_en = 1'b1; blen_wr_data = 16'd5; step(); blen_wr_en = 1'b0;
        buf_fill = 16'd3; step();
        check("R9 not ready below count", cfg_rd_data[3], 0);
        buf_fill = 16'd5; step();
        check("R9 auto ready", cfg_rd_data[3], 1);
        cfg_write(8'h04);
        do_in();
        check("R9 short packet sent", rsp_code, DAT);
        buf_fill = 16'd0;
        do_hack();
        check("R9 ready cleared after send", cfg_rd_data, 8'h00);
        blen_wr_en = 1'b1; blen_wr_data = 16'd0; step(); blen_wr_en = 1'b0;
    endtask

    task automatic t_clear();
        cfg_write(8'h08);
        check("R10 ready set", cfg_rd_data[3], 1);
        cfg_write(8'h18);
        check("R10 buf_clear pulse", buf_clear, 1);
        check("R10 ready cleared, clear bit reads 0", cfg_rd_data, 8'h00);
        step();
        check("R10 buf_clear one cycle", buf_clear, 0);
        cfg_write(8'hE0);
        check("R2 reserved read zero", cfg_rd_data, 8'h00);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_out_stage();
        t_in_stage();
        t_status();
        t_stall();
        t_autoval();
        t_clear();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule